// File: doc/BRIEF.md
# Touch ADC Command Sequencer

This block replays a short, software-loaded list of analog switch-matrix command words against a touch-panel converter. Software writes command words one at a time into a command port. Each non-zero word is appended to a small command store. A zero word closes the list, and a read of the command port rewinds the store so that a new list can be loaded. When command mode is set in the configuration register and the touch engine is enabled, the sequencer makes one sweep over the stored list.

For each command, the sequencer presents the command's switch, reference and input-select field to the converter. It waits a programmed number of settling cycles and then runs one or more conversions, keeping the result of the last one. Results are packed two per 32-bit word into a result FIFO, which software drains through a single touch-data port. At the end of the sweep, the block sets a touch-done status bit that drives the interrupt line, and it clears the engine enable. If the FIFO is full, the sequencer waits, so no result is ever dropped.

Top module: `touch_cmd_seq`

## Requirements
- R1: After reset, every readable register reads zero, `touch_irq` is low, `mux_ctrl` is zero and `adc_start` is low.
- R2: A non-zero write to the command port (offset 0x24) appends the word to the list. A zero write closes the list, and later non-zero writes are ignored. A read of the command port returns zero and rewinds the list to empty.
- R3: The list holds at most 8 commands. Non-zero writes beyond the eighth are ignored.
- R4: A sweep starts only when configuration bit 22 (offset 0x04) and engine bit 2 (offset 0x00) are both set. The engine bit clears itself at the end of the sweep and remains set while command mode is off.
- R5: While a command is active, `mux_ctrl` carries command bits 25..7 with bit 7 at `mux_ctrl[0]`. Within those bits, 10..7 select the input, 15..11 the positive reference, 19..16 the negative reference, 22..20 the ground switches and 25..23 the supply switches. The commands are presented in list order, and `mux_ctrl` is zero between commands and outside a sweep.
- R6: The first `adc_start` pulse for a command comes W+1 cycles after `mux_ctrl` first shows that command, where W is the 16-bit wait register at offset 0x10.
- R7: Each command runs N+1 single-cycle `adc_start` conversions, where N is the repeat register at offset 0x14. Only the last result is kept.
- R8: The results of commands 2k and 2k+1 form one word: command 2k goes in bits 11..0 and command 2k+1 in bits 27..16. All other bits are zero. For a list of odd length, the upper half of the final word is zero.
- R9: The end of a sweep sets status bit 2 (offset 0x0C), and `touch_irq` follows that bit. Writing 1 to bit 2 clears it.
- R10: A read of the touch-data port (offset 0x18) pops one word from the FIFO. A read of an empty FIFO returns zero. When the FIFO is full, the sequencer stalls before storing a word, and no word is lost.
- R11: A sweep over an empty list completes at once, with no conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| mux_ctrl | output | 19 | Switch/reference/input-select field of the active command |
| adc_start | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Converter result valid |
| adc_result | input | 12 | Converter result |
| touch_irq | output | 1 | Touch-done interrupt |

## Verification
Most internal faults show up at the ports within one command slot. A wrong list index changes the `mux_ctrl` value at the next `adc_start`. A settle counter that is off by one moves that pulse by a cycle. A repeat counter that is off changes both the number of conversions and which result is kept. Packing and FIFO pointer faults appear only when the data port is drained, and back-pressure faults appear only when a second sweep is run against a full FIFO. The scoreboard therefore compares every start pulse, and every popped word, against values derived from the list, the wait and repeat settings, and the conversion count.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam logic [7:0] OFF_ENGINE = 8'h00;
  localparam logic [7:0] OFF_CFG    = 8'h04;
  localparam logic [7:0] OFF_STATUS = 8'h0C;
  localparam logic [7:0] OFF_WAIT   = 8'h10;
  localparam logic [7:0] OFF_REPEAT = 8'h14;
  localparam logic [7:0] OFF_TDATA  = 8'h18;
  localparam logic [7:0] OFF_CMD    = 8'h24;

  localparam int ENG_TOUCH_BIT = 2;
  localparam int CFG_CMDMODE_BIT = 22;
  localparam int ST_DONE_BIT = 2;

  localparam int SEL_LO = 7;
  localparam int SEL_HI = 25;
  localparam int SEL_W  = SEL_HI - SEL_LO + 1;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETTLE,
    SQ_START,
    SQ_WAITC,
    SQ_STORE
  } sq_state_e;
endpackage

// File: rtl/tsq_cmd_store.sv
module tsq_cmd_store #(
  parameter int DEPTH = 8,
  parameter int SW    = 19,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_zero_i,
  input  logic [SW-1:0]    wr_sel_i,
  input  logic             rewind_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic [SW-1:0]    rd_sel_o,
  output logic [CNT_W-1:0] len_o
);
  logic [CNT_W-1:0] wptr_q, wptr_d;
  logic             closed_q, closed_d;
  logic             append;
  logic [SW-1:0]    store_q [DEPTH];

  assign append = wr_en_i && !wr_zero_i && !closed_q && (wptr_q < CNT_W'(DEPTH));

  always_comb begin
    wptr_d   = wptr_q;
    closed_d = closed_q;
    if (rewind_i) begin
      wptr_d   = '0;
      closed_d = 1'b0;
    end else if (wr_en_i && wr_zero_i) begin
      closed_d = 1'b1;
    end else if (append) begin
      wptr_d = wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      closed_q <= 1'b0;
    end else begin
      wptr_q   <= wptr_d;
      closed_q <= closed_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (append && !rewind_i && (wptr_q == CNT_W'(gi))) store_q[gi] <= wr_sel_i;
    end
  end

  assign rd_sel_o = (rd_idx_i < CNT_W'(DEPTH)) ? store_q[rd_idx_i[$clog2(DEPTH)-1:0]] : '0;
  assign len_o    = wptr_q;

  // R3: the list never grows past its capacity
  p_list_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !rewind_i && (wptr_q == CNT_W'(DEPTH))) |=> (wptr_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  slot_q [DEPTH];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push_i && !pop_i)      cnt_d = cnt_q + 1'b1;
    else if (pop_i && !push_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && (wr_q == AW'(gi))) slot_q[gi] <= din_i;
    end
  end

  assign dout_o  = slot_q[rd_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R10: the sequencer never stores into a full FIFO
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n) push_i |-> !full_o);
  // R10: the register side never pops an empty FIFO
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> !empty_o);
endmodule

// File: rtl/tsq_seq.sv
module tsq_seq
  import tsq_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int TMR_W = 16,
  parameter int RES_W = 12,
  parameter int SW    = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [SW-1:0]    sel_i,
  input  logic [TMR_W-1:0] wait_i,
  input  logic [TMR_W-1:0] same_i,
  input  logic             adc_done_i,
  input  logic [RES_W-1:0] adc_result_i,
  input  logic             fifo_full_i,
  output logic [CNT_W-1:0] idx_o,
  output logic [SW-1:0]    mux_ctrl_o,
  output logic             adc_start_o,
  output logic             push_o,
  output logic [31:0]      push_word_o,
  output logic             finish_o
);
  localparam int PAD = 16 - RES_W;

  sq_state_e        st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [TMR_W-1:0] wcnt_q, wcnt_d, rcnt_q, rcnt_d;
  logic [RES_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic             last_cmd, need_push;

  assign last_cmd  = (idx_q == len_i - 1'b1);
  assign need_push = idx_q[0] || last_cmd;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    wcnt_d   = wcnt_q;
    rcnt_d   = rcnt_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    push_o   = 1'b0;
    finish_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (go_i) begin
          if (len_i == '0) begin
            finish_o = 1'b1;
          end else begin
            idx_d  = '0;
            wcnt_d = wait_i;
            rcnt_d = same_i;
            st_d   = SQ_SETTLE;
          end
        end
      end
      SQ_SETTLE: begin
        if (wcnt_q == '0) st_d = SQ_START;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      SQ_START: st_d = SQ_WAITC;
      SQ_WAITC: begin
        if (adc_done_i) begin
          if (idx_q[0]) hi_d = adc_result_i;
          else          lo_d = adc_result_i;
          if (rcnt_q == '0) begin
            st_d = SQ_STORE;
          end else begin
            rcnt_d = rcnt_q - 1'b1;
            st_d   = SQ_START;
          end
        end
      end
      SQ_STORE: begin
        if (!(need_push && fifo_full_i)) begin
          push_o = need_push;
          if (last_cmd) begin
            finish_o = 1'b1;
            st_d     = SQ_IDLE;
          end else begin
            idx_d  = idx_q + 1'b1;
            wcnt_d = wait_i;
            rcnt_d = same_i;
            st_d   = SQ_SETTLE;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      wcnt_q <= '0;
      rcnt_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      wcnt_q <= wcnt_d;
      rcnt_q <= rcnt_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign idx_o       = idx_q;
  assign adc_start_o = (st_q == SQ_START);
  assign mux_ctrl_o  = (st_q == SQ_SETTLE || st_q == SQ_START || st_q == SQ_WAITC) ? sel_i : '0;
  assign push_word_o = {{PAD{1'b0}}, (idx_q[0] ? hi_q : {RES_W{1'b0}}), {PAD{1'b0}}, lo_q};

  // R7: each conversion request lasts exactly one cycle
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) adc_start_o |=> !adc_start_o);
  // R5: the selection field is held while the converter is working
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n) adc_start_o |=> $stable(mux_ctrl_o));
endmodule

// File: rtl/touch_cmd_seq.sv
module touch_cmd_seq
  import tsq_pkg::*;
#(
  parameter int CMD_DEPTH  = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int TMR_W      = 16,
  parameter int RES_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [SEL_W-1:0]  mux_ctrl,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_result,
  output logic              touch_irq
);
  localparam int CNT_W = $clog2(CMD_DEPTH + 1);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic             eng_q, eng_d, done_q, done_d;
  logic [31:0]      cfg_q, cfg_d;
  logic [TMR_W-1:0] wait_q, wait_d, same_q, same_d;

  logic             wr_eng, wr_cfg, wr_stat, wr_wait, wr_same, wr_cmd, rd_cmd, rd_data;
  logic             seq_finish, seq_push, fifo_full, fifo_empty, fifo_pop;
  logic [31:0]      seq_word, fifo_dout;
  logic [CNT_W-1:0] seq_idx, list_len;
  logic [SEL_W-1:0] cur_sel;

  assign wr_eng  = reg_wr && (reg_addr == OFF_ENGINE);
  assign wr_cfg  = reg_wr && (reg_addr == OFF_CFG);
  assign wr_stat = reg_wr && (reg_addr == OFF_STATUS);
  assign wr_wait = reg_wr && (reg_addr == OFF_WAIT);
  assign wr_same = reg_wr && (reg_addr == OFF_REPEAT);
  assign wr_cmd  = reg_wr && (reg_addr == OFF_CMD);
  assign rd_cmd  = reg_rd && (reg_addr == OFF_CMD);
  assign rd_data = reg_rd && (reg_addr == OFF_TDATA);
  assign fifo_pop = rd_data && !fifo_empty;

  always_comb begin
    eng_d  = eng_q;
    done_d = done_q;
    cfg_d  = cfg_q;
    wait_d = wait_q;
    same_d = same_q;
    if (seq_finish)  eng_d = 1'b0;
    else if (wr_eng) eng_d = reg_wdata[ENG_TOUCH_BIT];
    if (seq_finish)                             done_d = 1'b1;
    else if (wr_stat && reg_wdata[ST_DONE_BIT]) done_d = 1'b0;
    if (wr_cfg)  cfg_d  = reg_wdata;
    if (wr_wait) wait_d = reg_wdata[TMR_W-1:0];
    if (wr_same) same_d = reg_wdata[TMR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_q  <= 1'b0;
      done_q <= 1'b0;
      cfg_q  <= '0;
      wait_q <= '0;
      same_q <= '0;
    end else begin
      eng_q  <= eng_d;
      done_q <= done_d;
      cfg_q  <= cfg_d;
      wait_q <= wait_d;
      same_q <= same_d;
    end
  end

  tsq_cmd_store #(.DEPTH(CMD_DEPTH), .SW(SEL_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_en_i   (wr_cmd),
    .wr_zero_i (reg_wdata == 32'd0),
    .wr_sel_i  (reg_wdata[SEL_HI:SEL_LO]),
    .rewind_i  (rd_cmd),
    .rd_idx_i  (seq_idx),
    .rd_sel_o  (cur_sel),
    .len_o     (list_len)
  );

  tsq_seq #(.CNT_W(CNT_W), .TMR_W(TMR_W), .RES_W(RES_W), .SW(SEL_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_ni),
    .go_i         (eng_q && cfg_q[CFG_CMDMODE_BIT]),
    .len_i        (list_len),
    .sel_i        (cur_sel),
    .wait_i       (wait_q),
    .same_i       (same_q),
    .adc_done_i   (adc_done),
    .adc_result_i (adc_result),
    .fifo_full_i  (fifo_full),
    .idx_o        (seq_idx),
    .mux_ctrl_o   (mux_ctrl),
    .adc_start_o  (adc_start),
    .push_o       (seq_push),
    .push_word_o  (seq_word),
    .finish_o     (seq_finish)
  );

  tsq_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_ni),
    .push_i  (seq_push),
    .din_i   (seq_word),
    .pop_i   (fifo_pop),
    .dout_o  (fifo_dout),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFF_ENGINE: reg_rdata[ENG_TOUCH_BIT] = eng_q;
      OFF_CFG:    reg_rdata = cfg_q;
      OFF_STATUS: reg_rdata[ST_DONE_BIT] = done_q;
      OFF_WAIT:   reg_rdata[TMR_W-1:0] = wait_q;
      OFF_REPEAT: reg_rdata[TMR_W-1:0] = same_q;
      OFF_TDATA:  reg_rdata = fifo_empty ? 32'd0 : fifo_dout;
      default:    reg_rdata = '0;
    endcase
  end

  assign touch_irq = done_q;

  // R4: the engine enable drops once the sweep has ended
  p_engine_clear_r4: assert property (@(posedge clk) disable iff (!rst_ni) seq_finish |=> !eng_q);
  // R9: end of sweep raises the interrupt
  p_irq_on_finish_r9: assert property (@(posedge clk) disable iff (!rst_ni) seq_finish |=> touch_irq);
  // R9: write-one-to-clear of the done bit
  p_done_w1c_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_stat && reg_wdata[ST_DONE_BIT] && !seq_finish) |=> !touch_irq);
endmodule

// File: tb/tb_touch_cmd_seq.sv
module tb_touch_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [18:0] mux_ctrl;
  logic        adc_start;
  logic        adc_done = 1'b0;
  logic [11:0] adc_result = '0;
  logic        touch_irq;

  always #4 clk = ~clk;

  touch_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mux_ctrl(mux_ctrl),
    .adc_start(adc_start), .adc_done(adc_done), .adc_result(adc_result), .touch_irq(touch_irq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] exp_words[$];
  logic [18:0] exp_mux[$];
  logic [31:0] bcmd[8];
  int blen = 0;
  bit bclosed = 0;
  int cur_wait = 0, cur_same = 0;
  int nconv = 0, pend_k = 0, cd = 0, settle = 0;
  bit first = 1;

  function automatic logic [11:0] conv_val(int k);
    return 12'((k * 53 + 11) % 4096);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // converter model and start-pulse monitor
  always @(negedge clk) begin
    adc_done = 1'b0;
    if (cd != 0) begin
      cd = cd - 1;
      if (cd == 0) begin
        adc_done = 1'b1;
        adc_result = conv_val(pend_k);
      end
    end
    if (mux_ctrl == '0) begin
      settle = 0;
      first = 1;
    end else if (adc_start) begin
      if (first) begin
        logic [18:0] em;
        em = (exp_mux.size() > 0) ? exp_mux.pop_front() : 19'h7ffff;
        chk(mux_ctrl == em, "R5 select field", 32'(mux_ctrl), 32'(em));
        chk(settle == cur_wait + 1, "R6 settle cycles", 32'(settle), 32'(cur_wait + 1));
        first = 0;
      end
      pend_k = nconv;
      nconv++;
      cd = 3;
    end else if (first) begin
      settle++;
    end
  end

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rewind();
    logic [31:0] d;
    bus_read(8'h24, d);
    chk(d == 0, "R2 command port read", d, 0);
    blen = 0; bclosed = 0;
  endtask

  task automatic load_cmd(logic [31:0] w);
    bus_write(8'h24, w);
    if (w == 0) bclosed = 1;
    else if (!bclosed && blen < 8) begin bcmd[blen] = w; blen++; end
  endtask

  // driver side of the scoreboard: expected selections and packed words
  task automatic plan_sweep();
    int b = nconv;
    logic [11:0] lo = 0, hi;
    for (int c = 0; c < blen; c++) begin
      int k = b + c * (cur_same + 1) + cur_same;
      exp_mux.push_back(bcmd[c][25:7]);
      if (c % 2 == 0) lo = conv_val(k);
      else begin
        hi = conv_val(k);
        exp_words.push_back({4'b0, hi, 4'b0, lo});
      end
      if (c == blen - 1 && c % 2 == 0) exp_words.push_back({20'b0, lo});
    end
  endtask

  task automatic wait_done(string req);
    logic [31:0] d = 0;
    for (int i = 0; i < 4000 && d[2] == 0; i++) bus_read(8'h0C, d);
    chk(d[2] == 1, req, d, 32'h4);
  endtask

  task automatic drain(int n, string req);
    logic [31:0] d, e;
    for (int i = 0; i < n; i++) begin
      bus_read(8'h18, d);
      e = (exp_words.size() > 0) ? exp_words.pop_front() : 32'hdeadbeef;
      chk(d == e, req, d, e);
    end
  endtask

  task automatic set_timing(int w, int s);
    cur_wait = w; cur_same = s;
    bus_write(8'h10, 32'(w));
    bus_write(8'h14, 32'(s));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    bus_read(8'h00, d); chk(d == 0, "R1 engine reg", d, 0);
    bus_read(8'h04, d); chk(d == 0, "R1 config reg", d, 0);
    bus_read(8'h0C, d); chk(d == 0, "R1 status reg", d, 0);
    bus_read(8'h18, d); chk(d == 0, "R1 data port", d, 0);
    chk(touch_irq == 0 && mux_ctrl == 0 && adc_start == 0, "R1 outputs idle",
        {touch_irq, adc_start, 11'b0, mux_ctrl}, 0);

    // odd-length list, wait 3, single conversion
    set_timing(3, 0);
    bus_write(8'h04, 32'h0040_0000);
    rewind();
    load_cmd(32'h0021_8100);
    load_cmd(32'h0410_8400);
    load_cmd(32'h0009_0280);
    load_cmd(32'h0);
    base = nconv;
    plan_sweep();
    bus_write(8'h00, 32'h4);
    wait_done("R9 done after sweep");
    chk(touch_irq == 1, "R9 irq high", 32'(touch_irq), 1);
    bus_read(8'h00, d); chk(d == 0, "R4 engine self-clear", d, 0);
    chk(nconv - base == 3, "R7 conversions single", 32'(nconv - base), 3);
    drain(2, "R8 packed odd list");
    bus_read(8'h18, d); chk(d == 0, "R10 empty read", d, 0);
    bus_write(8'h0C, 32'h4);
    @(negedge clk);
    chk(touch_irq == 0, "R9 w1c clears irq", 32'(touch_irq), 0);

    // engine without command mode
    bus_write(8'h04, 32'h0000_0000);
    base = nconv;
    bus_write(8'h00, 32'h4);
    repeat (60) @(negedge clk);
    chk(nconv == base, "R4 no sweep without mode", 32'(nconv - base), 0);
    bus_read(8'h00, d); chk(d == 32'h4, "R4 engine stays set", d, 4);
    bus_read(8'h0C, d); chk(d == 0, "R4 no done without mode", d, 0);
    bus_write(8'h00, 32'h0);

    // writes after the terminator are ignored
    bus_write(8'h04, 32'h0040_0000);
    set_timing(1, 1);
    rewind();
    load_cmd(32'h0200_0080);
    load_cmd(32'h0100_4100);
    load_cmd(32'h0);
    load_cmd(32'h0080_0200);
    base = nconv;
    plan_sweep();
    bus_write(8'h00, 32'h4);
    wait_done("R2 done after short list");
    chk(nconv - base == 4, "R2 list closed by zero", 32'(nconv - base), 4);
    drain(1, "R2 closed list data");
    bus_write(8'h0C, 32'h4);

    // overlong list, wait 0, two repeats
    set_timing(0, 2);
    rewind();
    for (int i = 0; i < 10; i++) load_cmd(32'((i + 1) << 7) | 32'h0080_0000);
    load_cmd(32'h0);
    base = nconv;
    plan_sweep();
    bus_write(8'h00, 32'h4);
    wait_done("R3 done after full list");
    chk(nconv - base == 24, "R3 capped at eight", 32'(nconv - base), 24);
    chk(nconv - base == 24, "R7 repeat count", 32'(nconv - base), 24);
    bus_write(8'h0C, 32'h4);

    // second sweep into a full FIFO
    base = nconv;
    plan_sweep();
    bus_write(8'h00, 32'h4);
    repeat (200) @(negedge clk);
    bus_read(8'h0C, d); chk(d == 0, "R10 stalled no done", d, 0);
    chk(nconv - base == 6, "R10 stalled at first pair", 32'(nconv - base), 6);
    drain(4, "R10 first sweep words");
    wait_done("R10 resumes after drain");
    drain(4, "R10 second sweep words");
    bus_read(8'h18, d); chk(d == 0, "R10 empty after drain", d, 0);
    bus_write(8'h0C, 32'h4);

    // empty list
    rewind();
    load_cmd(32'h0);
    base = nconv;
    bus_write(8'h00, 32'h4);
    wait_done("R11 empty list done");
    chk(nconv == base, "R11 no conversions", 32'(nconv - base), 0);
    bus_read(8'h18, d); chk(d == 0, "R11 no data", d, 0);
    chk(mux_ctrl == 0, "R5 idle select zero", 32'(mux_ctrl), 0);
    chk(exp_mux.size() == 0, "R5 all commands presented", 32'(exp_mux.size()), 0);
    bus_write(8'h0C, 32'h4);

    summary();
  end
endmodule